// File: doc/BRIEF.md
# Multiplexed Input Row Reader

This block lets a processor scan four rows of active-low switches over a byte-wide I/O bus. Software writes a select byte. Its low four bits pick which switch rows are merged onto a data port. A second read port shows which rows have any switch held, whatever the select byte holds. Four bytes of configuration switches can also be read at their own ports. Every switch input is treated as asynchronous and passes through a two-flop synchronizer before any logic uses it.

A small bus state machine handles the bus side. It has three states:
- `ST_IDLE`: no access in progress.
- `ST_READ`: a read response is on the data output.
- `ST_WRITE`: a write has just been accepted.

From any state, the transitions are:
- to `ST_READ` when the read strobe is high;
- otherwise to `ST_WRITE` when the write strobe is high;
- otherwise to `ST_IDLE`.

The read result is captured on the clock edge that samples the read strobe. It is driven on `bus_rdata` only while the state is `ST_READ`.

Top module: `mux_row_reader`

## Requirements
- R1: After synchronous reset, the select byte is 0x00, the bus is in `ST_IDLE` and `bus_rdata` reads 0x00.
- R2: A write to port 0x12 stores `bus_wdata` in the select byte. A read of port 0x12 returns the last value stored.
- R3: A read of port 0x04 returns the bitwise OR of every row i (i = 0..3) whose select bit i is 1. Row i is `sw_rows[8i+7:8i]`. Select bits 7..4 have no effect.
- R4: A read of port 0x04 returns 0x00 when select bits 3..0 are all 0.
- R5: A read of port 0x05 returns a status byte. Bit i (i = 0..3) is 0 when row i is not 0xFF, and 1 when row i is 0xFF. Bits 7..4 are always 1. The select byte has no effect on this port.
- R6: A read of port k (k = 0..3) returns configuration byte k, which is `cfg_sw[8k+7:8k]`.
- R7: A read of any port other than 0x00-0x05 and 0x12 returns 0xFF.
- R8: A read strobe sampled on a clock edge places its result on `bus_rdata` for the following cycle. In any cycle whose preceding edge did not sample a read strobe, `bus_rdata` is 0x00. Reads have no side effects.
- R9: A switch input change made between edges is first seen by a read sampled on the third edge after the change. A read sampled on the second edge still returns the old value.
- R10: A write to any port other than 0x12 leaves the select byte unchanged.
- R11: When both strobes are high on the same edge, the read is served and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | I/O port address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid in the cycle after a read strobe |
| sw_rows | input | 32 | Four active-low switch rows, row i at bits 8i+7:8i |
| cfg_sw | input | 32 | Four configuration switch bytes, byte k at bits 8k+7:8k |

## Verification
Read results are due exactly one edge after the read strobe is sampled. The bench raises the strobe at a falling edge, drops it at the next falling edge, and samples `bus_rdata` there. A write takes effect on the edge that samples it, so a read issued on the next falling edge already sees the new select byte. Switch changes need two synchronizer edges before a read can see them. The table-driven tests therefore wait several cycles after changing the rows, and one directed test issues reads on the second and third edges after a change to pin the latency down.

// File: rtl/mux_row_reader_pkg.sv
package mux_row_reader_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] PORT_CFG_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] PORT_DATA     = 8'h04;
    localparam logic [ADDR_W-1:0] PORT_STATUS   = 8'h05;
    localparam logic [ADDR_W-1:0] PORT_SELECT   = 8'h12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_t;
endpackage

// File: rtl/mrr_sync.sv
module mrr_sync #(
    parameter int              WIDTH   = 8,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/mrr_row_merge.sv
module mrr_row_merge #(
    parameter int NUM_ROWS = 4,
    parameter int ROW_W    = 8
) (
    input  logic [NUM_ROWS*ROW_W-1:0] rows,
    input  logic [NUM_ROWS-1:0]       row_en,
    output logic [ROW_W-1:0]          merged,
    output logic [ROW_W-1:0]          active_n
);
    logic [ROW_W-1:0] masked [NUM_ROWS];
    logic [NUM_ROWS-1:0] idle_row;

    // Per-row gating and idle detection
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign masked[r]   = row_en[r] ? rows[r*ROW_W +: ROW_W] : '0;
        assign idle_row[r] = &rows[r*ROW_W +: ROW_W];
    end

    always_comb begin
        merged = '0;
        for (int r = 0; r < NUM_ROWS; r++) merged = merged | masked[r];
    end

    // Status byte: one bit per row, unused upper bits idle high
    for (genvar b = 0; b < ROW_W; b++) begin : g_stat
        if (b < NUM_ROWS) begin : g_live
            assign active_n[b] = idle_row[b];
        end else begin : g_pad
            assign active_n[b] = 1'b1;
        end
    end
endmodule

// File: rtl/mrr_bus_regs.sv
module mrr_bus_regs
    import mux_row_reader_pkg::*;
#(
    parameter int NUM_CFG = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [DATA_W-1:0]         merged,
    input  logic [DATA_W-1:0]         active_n,
    input  logic [NUM_CFG*DATA_W-1:0] cfg_bytes,
    output logic [DATA_W-1:0]         sel_q,
    output logic [DATA_W-1:0]         bus_rdata
);
    bus_state_t       state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] lookup;

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (bus_rd)      state_d = ST_READ;
                else if (bus_wr) state_d = ST_WRITE;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Port decode for reads
    always_comb begin
        lookup = '1;
        if (bus_addr == PORT_DATA)        lookup = merged;
        else if (bus_addr == PORT_STATUS) lookup = active_n;
        else if (bus_addr == PORT_SELECT) lookup = sel_q;
        else begin
            for (int k = 0; k < NUM_CFG; k++) begin
                if (bus_addr == PORT_CFG_BASE + ADDR_W'(k))
                    lookup = cfg_bytes[k*DATA_W +: DATA_W];
            end
        end
    end

    // Data registers loaded on state entry
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (state_d == ST_READ) rdata_q <= lookup;
            if (state_d == ST_WRITE && bus_addr == PORT_SELECT) sel_q <= bus_wdata;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_READ:  bus_rdata = rdata_q;
            ST_IDLE,
            ST_WRITE: bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mux_row_reader.sv
module mux_row_reader
    import mux_row_reader_pkg::*;
#(
    parameter int NUM_ROWS    = 4,
    parameter int NUM_CFG     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_ROWS*DATA_W-1:0] sw_rows,
    input  logic [NUM_CFG*DATA_W-1:0]  cfg_sw
);
    localparam int ROWS_BITS = NUM_ROWS * DATA_W;
    localparam int CFG_BITS  = NUM_CFG * DATA_W;

    logic [ROWS_BITS-1:0] rows_s;
    logic [CFG_BITS-1:0]  cfg_s;
    logic [DATA_W-1:0]    merged;
    logic [DATA_W-1:0]    active_n;
    logic [DATA_W-1:0]    sel_q;

    mrr_sync #(.WIDTH(ROWS_BITS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_rows (
        .clk(clk), .rst(rst), .d_async(sw_rows), .q_sync(rows_s)
    );

    mrr_sync #(.WIDTH(CFG_BITS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_cfg (
        .clk(clk), .rst(rst), .d_async(cfg_sw), .q_sync(cfg_s)
    );

    mrr_row_merge #(.NUM_ROWS(NUM_ROWS), .ROW_W(DATA_W)) u_merge (
        .rows(rows_s), .row_en(sel_q[NUM_ROWS-1:0]),
        .merged(merged), .active_n(active_n)
    );

    mrr_bus_regs #(.NUM_CFG(NUM_CFG)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .merged(merged), .active_n(active_n),
        .cfg_bytes(cfg_s), .sel_q(sel_q), .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/mux_row_reader_chk.sv
module mux_row_reader_chk
    import mux_row_reader_pkg::*;
#(
    parameter int NUM_ROWS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] sel_q
);
    logic              prev_rd;
    logic [ADDR_W-1:0] prev_addr;
    logic              prev_unmapped;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rd   <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_rd   <= bus_rd;
            prev_addr <= bus_addr;
        end
    end

    assign prev_unmapped = (prev_addr > PORT_STATUS) && (prev_addr != PORT_SELECT);

    // R8: no read sampled on the previous edge means the bus output is zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !prev_rd |-> bus_rdata == '0);

    // R7: unmapped ports read all ones
    p_unmapped_ff_r7: assert property (@(posedge clk) disable iff (rst)
        (prev_rd && prev_unmapped) |-> bus_rdata == 8'hFF);

    // R4: data port with no row enabled reads zero
    p_no_row_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == PORT_DATA && sel_q[NUM_ROWS-1:0] == '0) |=> bus_rdata == '0);

    // R2: select port reads back the stored byte
    p_sel_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == PORT_SELECT) |=> bus_rdata == $past(sel_q));

    // R10, R11: select byte changes only on a write-only access to its port
    p_sel_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && !bus_rd && bus_addr == PORT_SELECT) |=> $stable(sel_q));

    // R5: status bits above the row count stay high
    p_status_pad_r5: assert property (@(posedge clk) disable iff (rst)
        (prev_rd && prev_addr == PORT_STATUS) |-> &bus_rdata[DATA_W-1:NUM_ROWS]);
endmodule

bind mux_row_reader mux_row_reader_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .sel_q(sel_q)
);

// File: tb/mux_row_reader_test.sv
module mux_row_reader_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [31:0] sw_rows = 32'hFFFF_FFFF;
    logic [31:0] cfg_sw = 32'hFFFF_FFFF;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mux_row_reader uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sw_rows(sw_rows), .cfg_sw(cfg_sw)
    );

    // {rows, select, expected data, expected status}
    localparam int NVEC = 11;
    localparam logic [55:0] VEC [NVEC] = '{
        {32'hFFFF_FFFF, 8'h01, 8'hFF, 8'hFF},
        {32'hFFFF_FFFE, 8'h01, 8'hFE, 8'hFE},
        {32'hFFFF_FDFF, 8'h02, 8'hFD, 8'hFD},
        {32'hFFFF_FDFE, 8'h03, 8'hFF, 8'hFC},
        {32'h5AFF_FFFF, 8'h08, 8'h5A, 8'hF7},
        {32'h1234_5678, 8'h05, 8'h7C, 8'hF0},
        {32'h1234_5678, 8'h0A, 8'h56, 8'hF0},
        {32'h1234_5678, 8'hF0, 8'h00, 8'hF0},
        {32'h0000_0000, 8'h0F, 8'h00, 8'hF0},
        {32'hFFFF_FFFF, 8'h00, 8'h00, 8'hFF},
        {32'h0102_0408, 8'h0F, 8'h0F, 8'hF0}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        idle(3);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        check("R1 idle output", bus_rdata, 8'h00);
        rd(8'h12, v); check("R1 select after reset", v, 8'h00);

        // Table walk: R2, R3, R4, R5
        for (int i = 0; i < NVEC; i++) begin
            sw_rows = VEC[i][55:24];
            idle(4);
            wr(8'h12, VEC[i][23:16]);
            rd(8'h12, v); check("R2 select readback", v, VEC[i][23:16]);
            rd(8'h04, v); check("R3 R4 merged data", v, VEC[i][15:8]);
            rd(8'h05, v); check("R5 row status", v, VEC[i][7:0]);
        end

        // R5: status ignores select
        sw_rows = 32'hFFEF_FFFF; idle(4);
        wr(8'h12, 8'h00);
        rd(8'h05, v); check("R5 status with select 0", v, 8'hFB);

        // R6: configuration bytes
        cfg_sw = 32'hA1B2_C3D4; idle(4);
        rd(8'h00, v); check("R6 cfg 0", v, 8'hD4);
        rd(8'h01, v); check("R6 cfg 1", v, 8'hC3);
        rd(8'h02, v); check("R6 cfg 2", v, 8'hB2);
        rd(8'h03, v); check("R6 cfg 3", v, 8'hA1);

        // R7: unmapped ports
        rd(8'h06, v); check("R7 port 06", v, 8'hFF);
        rd(8'h11, v); check("R7 port 11", v, 8'hFF);
        rd(8'h13, v); check("R7 port 13", v, 8'hFF);
        rd(8'hFF, v); check("R7 port FF", v, 8'hFF);

        // R8: output returns to zero one cycle after a read
        rd(8'h00, v);
        @(negedge clk); check("R8 idle after read", bus_rdata, 8'h00);
        rd(8'h00, v); check("R8 read no side effect", v, 8'hD4);

        // R10: writes elsewhere leave select alone
        wr(8'h12, 8'h01);
        wr(8'h04, 8'h0F);
        wr(8'h13, 8'h0E);
        wr(8'h00, 8'h0C);
        rd(8'h12, v); check("R10 select unchanged", v, 8'h01);

        // R11: simultaneous strobes
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 8'h12; bus_wdata = 8'h55;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check("R11 read served", bus_rdata, 8'h01);
        rd(8'h12, v); check("R11 write dropped", v, 8'h01);

        // R9: synchronizer latency
        sw_rows = 32'hFFFF_FFFF; idle(4);
        @(negedge clk); sw_rows = 32'hFFFF_FF3C;
        @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h04;
        @(negedge clk); check("R9 second edge old", bus_rdata, 8'hFF);
        @(negedge clk); bus_rd = 1'b0; check("R9 third edge new", bus_rdata, 8'h3C);

        // R1: reset mid-run clears select
        wr(8'h12, 8'hA5);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1 output after reset", bus_rdata, 8'h00);
        rd(8'h12, v); check("R1 select cleared", v, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule